// File: doc/BRIEF.md
# Two-Phase Comparator Offset Calibration Controller

This block sequences offset trimming for an array of dynamic comparators that share one pair of trim DACs. A single global sequencer ramps a coarse trim code one step per clock, then a fine trim code one step per clock. Both codes go to shared DACs that every comparator in the array sees. Each comparator has a small local slice. The slice records which way its comparator leaned when calibration began and connects the shared coarse ramp to the compensation side that opposes that lean. It stores the coarse code on the cycle its decision turns over. It then tracks the fine ramp and stores the fine code on the next turnover.

Software or a power-up sequencer pulses the start input while the block is idle. The block then runs one coarse sweep and one full fine sweep. Each comparator's done flag rises as soon as its own fine code is stored, and the flag stays high until the next calibration starts. The stored codes are presented per comparator so that local analog holding circuits can keep their trim.

Top module: `offset_cal_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after reset is applied, both shared codes, every stored trim, every done flag and every switch output read zero, including when reset arrives in the middle of a sweep.
- R2: A start seen while idle begins the coarse phase. On the next cycle the coarse code reads 0, and it then rises by exactly 1 each cycle.
- R3: At the start edge each slice stores its comparator decision as its polarity. Polarity 0 drives sw_pos and polarity 1 drives sw_neg. The switch is high only while the slice is tracking the coarse ramp, and sw_pos and sw_neg are never high together.
- R4: A coarse-tracking slice stores the coarse code present on the first edge at which its decision differs from its polarity. On that edge its switch opens.
- R5: The coarse phase ends on the edge at which every slice has stored its coarse code, or on the edge at which the coarse code is 63. A slice that never turned over stores 63. On the next cycle the coarse code reads 0 and the fine code reads 0.
- R6: The fine code rises by 1 per cycle from 0 to 1023. After 1023 the block returns to idle, where both codes read 0.
- R7: At fine entry each slice samples its decision. It stores the fine code present on the first later edge at which the decision differs from that sample, and it stores 1023 if no such edge comes before the sweep ends. On that edge fine_en falls and the done flag rises.
- R8: A start pulse while a sweep is running has no effect: the codes keep ramping and the stored trims are unchanged.
- R9: Done flags stay high after the sweep ends. A new accepted start clears the done flags and the stored trims of every slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Calibration start request, accepted only while idle |
| cmp_dec | input | N_CMP | Decision bit of each comparator |
| coarse_code | output | C_W | Shared coarse DAC code |
| fine_code | output | F_W | Shared fine DAC code |
| sw_pos | output | N_CMP | Connect coarse ramp to positive-side compensation |
| sw_neg | output | N_CMP | Connect coarse ramp to negative-side compensation |
| fine_en | output | N_CMP | Slice is tracking the fine ramp |
| cal_done | output | N_CMP | Slice has stored its fine code |
| coarse_trim | output | N_CMP*C_W | Stored coarse code per slice, slice i at bits i*C_W upward |
| fine_trim | output | N_CMP*F_W | Stored fine code per slice, slice i at bits i*F_W upward |

## Verification
Every result here is one register stage away from its cause. The first code value appears one edge after the start edge. A trim is stored, and a switch opens, on the edge that follows the decision change, and the phase handoff shows on the cycle after the last slice turns over. The bench acts as the comparators. On each falling edge it computes each decision from the code on the ports and a per-comparator threshold, and it reads results on later falling edges, so every comparison falls exactly one rising edge after the stimulus that caused it. The thresholds are chosen so that the expected stored codes are the thresholds themselves, clipped at 63 and 1023.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COARSE = 2'd1,
        SEQ_FINE   = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        SL_IDLE  = 3'd0,
        SL_CTRK  = 3'd1,
        SL_CWAIT = 3'd2,
        SL_FTRK  = 3'd3,
        SL_DONE  = 3'd4
    } slice_state_e;

endpackage

// File: rtl/ofc_sequencer.sv
module ofc_sequencer
    import ofc_pkg::*;
#(
    parameter int C_W = 6,
    parameter int F_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           all_left,
    output logic [C_W-1:0] coarse_code,
    output logic [F_W-1:0] fine_code,
    output logic           start_acc,
    output logic           go_fine,
    output logic           fine_last
);

    localparam logic [C_W-1:0] C_MAX = '1;
    localparam logic [F_W-1:0] F_MAX = '1;

    typedef struct packed {
        seq_state_e     st;
        logic [C_W-1:0] cc;
        logic [F_W-1:0] fc;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d         = q;
        start_acc = 1'b0;
        go_fine   = 1'b0;
        fine_last = 1'b0;
        case (q.st)
            SEQ_IDLE: begin
                if (start) begin
                    start_acc = 1'b1;
                    d.st      = SEQ_COARSE;
                    d.cc      = '0;
                    d.fc      = '0;
                end
            end
            SEQ_COARSE: begin
                if (all_left || q.cc == C_MAX) begin
                    go_fine = 1'b1;
                    d.st    = SEQ_FINE;
                    d.cc    = '0;
                    d.fc    = '0;
                end else begin
                    d.cc = q.cc + 1'b1;
                end
            end
            SEQ_FINE: begin
                if (q.fc == F_MAX) begin
                    fine_last = 1'b1;
                    d.st      = SEQ_IDLE;
                    d.fc      = '0;
                end else begin
                    d.fc = q.fc + 1'b1;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= SEQ_IDLE;
            q.cc <= '0;
            q.fc <= '0;
        end else begin
            q <= d;
        end
    end

    assign coarse_code = q.cc;
    assign fine_code   = q.fc;

    // R2
    coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_COARSE && !go_fine) |=> (coarse_code == $past(coarse_code) + 1'b1));

    // R6
    fine_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_FINE && !fine_last) |=> (fine_code == $past(fine_code) + 1'b1));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_FINE) |=> (q.st != SEQ_COARSE));

endmodule

// File: rtl/ofc_slice.sv
module ofc_slice
    import ofc_pkg::*;
#(
    parameter int C_W = 6,
    parameter int F_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_acc,
    input  logic           go_fine,
    input  logic           fine_last,
    input  logic [C_W-1:0] coarse_code,
    input  logic [F_W-1:0] fine_code,
    input  logic           cmp,
    output logic           left,
    output logic           sw_pos,
    output logic           sw_neg,
    output logic           fine_en,
    output logic           done,
    output logic [C_W-1:0] ctrim,
    output logic [F_W-1:0] ftrim
);

    typedef struct packed {
        slice_state_e   st;
        logic           pol;
        logic           fref;
        logic [C_W-1:0] ct;
        logic [F_W-1:0] ft;
    } slice_t;

    slice_t q, d;
    logic   c_flip;
    logic   f_flip;

    assign c_flip = (cmp != q.pol);
    assign f_flip = (cmp != q.fref);
    assign left   = (q.st == SL_CWAIT) || (q.st == SL_CTRK && c_flip);

    always_comb begin
        d = q;
        if (start_acc) begin
            d.st   = SL_CTRK;
            d.pol  = cmp;
            d.fref = 1'b0;
            d.ct   = '0;
            d.ft   = '0;
        end else begin
            case (q.st)
                SL_CTRK: begin
                    if (go_fine) begin
                        d.ct   = coarse_code;
                        d.st   = SL_FTRK;
                        d.fref = cmp;
                    end else if (c_flip) begin
                        d.ct = coarse_code;
                        d.st = SL_CWAIT;
                    end
                end
                SL_CWAIT: begin
                    if (go_fine) begin
                        d.st   = SL_FTRK;
                        d.fref = cmp;
                    end
                end
                SL_FTRK: begin
                    if (f_flip || fine_last) begin
                        d.ft = fine_code;
                        d.st = SL_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= SL_IDLE;
            q.pol  <= 1'b0;
            q.fref <= 1'b0;
            q.ct   <= '0;
            q.ft   <= '0;
        end else begin
            q <= d;
        end
    end

    assign sw_pos  = (q.st == SL_CTRK) && !q.pol;
    assign sw_neg  = (q.st == SL_CTRK) &&  q.pol;
    assign fine_en = (q.st == SL_FTRK);
    assign done    = (q.st == SL_DONE);
    assign ctrim   = q.ct;
    assign ftrim   = q.ft;

    // R3
    side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_pos && sw_neg));

    // R4
    coarse_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SL_CTRK && c_flip && !start_acc) |=> (ctrim == $past(coarse_code) && !sw_pos && !sw_neg));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_acc) |=> done);

    // R7
    fine_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_en && fine_last) |=> (done && ftrim == $past(fine_code)));

endmodule

// File: rtl/offset_cal_ctrl.sv
module offset_cal_ctrl #(
    parameter int N_CMP = 4,
    parameter int C_W   = 6,
    parameter int F_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_start,
    input  logic [N_CMP-1:0]     cmp_dec,
    output logic [C_W-1:0]       coarse_code,
    output logic [F_W-1:0]       fine_code,
    output logic [N_CMP-1:0]     sw_pos,
    output logic [N_CMP-1:0]     sw_neg,
    output logic [N_CMP-1:0]     fine_en,
    output logic [N_CMP-1:0]     cal_done,
    output logic [N_CMP*C_W-1:0] coarse_trim,
    output logic [N_CMP*F_W-1:0] fine_trim
);

    logic             start_acc;
    logic             go_fine;
    logic             fine_last;
    logic [N_CMP-1:0] left_vec;
    logic             all_left;

    assign all_left = &left_vec;

    ofc_sequencer #(
        .C_W (C_W),
        .F_W (F_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cal_start),
        .all_left    (all_left),
        .coarse_code (coarse_code),
        .fine_code   (fine_code),
        .start_acc   (start_acc),
        .go_fine     (go_fine),
        .fine_last   (fine_last)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_slice
        ofc_slice #(
            .C_W (C_W),
            .F_W (F_W)
        ) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_acc   (start_acc),
            .go_fine     (go_fine),
            .fine_last   (fine_last),
            .coarse_code (coarse_code),
            .fine_code   (fine_code),
            .cmp         (cmp_dec[i]),
            .left        (left_vec[i]),
            .sw_pos      (sw_pos[i]),
            .sw_neg      (sw_neg[i]),
            .fine_en     (fine_en[i]),
            .done        (cal_done[i]),
            .ctrim       (coarse_trim[i*C_W +: C_W]),
            .ftrim       (fine_trim[i*F_W +: F_W])
        );
    end

    // R6
    code_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_code != '0) |-> (fine_code == '0));

    // R5
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_en != '0) |-> ((sw_pos | sw_neg) == '0));

endmodule

// File: tb/offset_cal_ctrl_bench.sv
`timescale 1ns/1ps
module offset_cal_ctrl_bench;

    localparam int N  = 4;
    localparam int CW = 6;
    localparam int FW = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cal_start = 1'b0;
    logic [N-1:0]    cmp_dec = '0;
    logic [CW-1:0]   coarse_code;
    logic [FW-1:0]   fine_code;
    logic [N-1:0]    sw_pos, sw_neg, fine_en, cal_done;
    logic [N*CW-1:0] coarse_trim;
    logic [N*FW-1:0] fine_trim;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int     ct   [N];
    int     ft   [N];
    logic   pol  [N];
    logic   flipped [N];

    always #2 clk = ~clk;

    offset_cal_ctrl #(.N_CMP(N), .C_W(CW), .F_W(FW)) u_offset_cal_ctrl (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_dec(cmp_dec),
        .coarse_code(coarse_code), .fine_code(fine_code),
        .sw_pos(sw_pos), .sw_neg(sw_neg), .fine_en(fine_en), .cal_done(cal_done),
        .coarse_trim(coarse_trim), .fine_trim(fine_trim)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000) begin
            fails = fails + 1;
            $display("FAIL R6 watchdog expired actual=%0d expected<%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // comparator model: decision from code on ports and per-comparator threshold
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            logic base;
            if ((sw_pos[i] || sw_neg[i]) && int'(coarse_code) >= ct[i])
                flipped[i] = 1'b1;
            base = flipped[i] ? !pol[i] : pol[i];
            if (fine_en[i] && int'(fine_code) >= ft[i])
                cmp_dec[i] = !base;
            else
                cmp_dec[i] = base;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [N-1:0] p, input int c0, c1, c2, c3,
                         input int f0, f1, f2, f3);
        ct[0] = c0; ct[1] = c1; ct[2] = c2; ct[3] = c3;
        ft[0] = f0; ft[1] = f1; ft[2] = f2; ft[3] = f3;
        for (int i = 0; i < N; i++) begin
            pol[i]     = p[i];
            flipped[i] = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    task automatic wait_code(input int val, input bit fine);
        for (int k = 0; k < 1200; k++) begin
            if ((fine ? int'(fine_code) : int'(coarse_code)) == val) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle(output int max_fine);
        max_fine = 0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (int'(fine_code) > max_fine) max_fine = int'(fine_code);
            if (fine_code == '0 && coarse_code == '0 && cal_done == '1) break;
        end
    endtask

    task automatic check_trims(input int ec0, ec1, ec2, ec3, input int ef0, ef1, ef2, ef3);
        int ec[N];
        int ef[N];
        ec[0] = ec0; ec[1] = ec1; ec[2] = ec2; ec[3] = ec3;
        ef[0] = ef0; ef[1] = ef1; ef[2] = ef2; ef[3] = ef3;
        for (int i = 0; i < N; i++) begin
            chk("R4/R5 coarse trim", coarse_trim[i*CW +: CW], ec[i]);
            chk("R7 fine trim", fine_trim[i*FW +: FW], ef[i]);
        end
    endtask

    task automatic check_all_zero(input string tag);
        chk(tag, coarse_code, 0);
        chk(tag, fine_code, 0);
        chk(tag, coarse_trim, 0);
        chk(tag, fine_trim, 0);
        chk(tag, cal_done, 0);
        chk(tag, sw_pos | sw_neg | fine_en, 0);
    endtask

    task automatic t_reset();
        check_all_zero("R1 reset state");
    endtask

    task automatic t_mixed();
        int mf;
        setup(4'b1010, 5, 12, 3, 20, 100, 7, 0, 500);
        pulse_start();
        chk("R2 first coarse code", coarse_code, 0);
        chk("R9 start clears done", cal_done, 0);
        chk("R9 start clears trims", coarse_trim, 0);
        chk("R3 sw_pos side", sw_pos, 4'b0101);
        chk("R3 sw_neg side", sw_neg, 4'b1010);
        @(negedge clk);
        chk("R2 coarse step", coarse_code, 1);
        wait_code(4, 1'b0);
        @(negedge clk);
        chk("R4 switch opens after turnover", sw_pos[2], 0);
        chk("R4 early store", coarse_trim[2*CW +: CW], 3);
        wait_code(20, 1'b0);
        @(negedge clk);
        chk("R5 handoff coarse code", coarse_code, 0);
        chk("R5 handoff fine code", fine_code, 0);
        chk("R7 fine tracking", fine_en, 4'b1111);
        @(negedge clk);
        chk("R6 fine step", fine_code, 1);
        wait_idle(mf);
        chk("R6 fine reaches full scale", mf, 1023);
        chk("R9 done held in idle", cal_done, 4'b1111);
        check_trims(5, 12, 3, 20, 100, 7, 0, 500);
    endtask

    task automatic t_saturate();
        int mf;
        setup(4'b0011, 64, 10, 64, 2, 2000, 30, 1, 2000);
        pulse_start();
        chk("R9 new start clears done", cal_done, 0);
        chk("R9 new start clears fine trims", fine_trim, 0);
        wait_code(63, 1'b0);
        chk("R5 still coarse at 63", fine_en, 0);
        @(negedge clk);
        chk("R5 saturation handoff", coarse_code, 0);
        chk("R5 saturation fine code", fine_code, 0);
        wait_idle(mf);
        chk("R6 return to idle", coarse_code + fine_code, 0);
        check_trims(63, 10, 63, 2, 1023, 30, 1, 1023);
    endtask

    task automatic t_ignore_start();
        int mf;
        setup(4'b0110, 8, 9, 10, 11, 40, 60, 80, 90);
        pulse_start();
        wait_code(50, 1'b1);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk("R8 fine keeps ramping", fine_code, 51);
        chk("R8 coarse not restarted", coarse_code, 0);
        chk("R8 early trim kept", coarse_trim[0 +: CW], 8);
        @(negedge clk);
        chk("R8 fine ramp continues", fine_code, 52);
        wait_idle(mf);
        check_trims(8, 9, 10, 11, 40, 60, 80, 90);
    endtask

    task automatic t_mid_reset();
        setup(4'b0001, 2, 3, 40, 40, 10, 10, 10, 10);
        pulse_start();
        wait_code(5, 1'b0);
        chk("R4 trim stored before reset", coarse_trim[0 +: CW], 2);
        rst_n = 1'b0;
        @(negedge clk);
        check_all_zero("R1 mid-sweep reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1 after release");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            ct[i] = 0; ft[i] = 0; pol[i] = 1'b0; flipped[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mixed();
        t_saturate();
        t_ignore_start();
        t_mid_reset();
        t_mixed();
        summary();
        $finish;
    end

endmodule